// File: doc/BRIEF.md
# Predicate-to-Vector Bit Packer

This block moves a predicate into a vector register. A predicate holds one flag bit per vector byte. For an element size of E bytes, only every E-th flag matters. The block collects those flags into a dense field that is `VL/E` bits wide, where VL is the current vector length in bytes. It then writes the field into one segment of the destination vector. The destination arrives on `vec_in`, so the block performs a read-modify-write, and the updated vector comes out on `vec_out`.

Insertion is asymmetric:
- A segment index of zero writes the field to the bottom of the vector and clears every other bit.
- A nonzero index replaces only its own segment and keeps the rest of `vec_in`.

The block always forces bits at or above the current vector length to zero. A one-cycle `start` pulse launches an operation. The result and a one-cycle `done` appear on the next clock edge.

Top module: `pred_vec_packer`

## Requirements
- R1: While reset is held and after it is released, `vec_out` is all zero and `done` is low, until the first `start`.
- R2: `done` is high for exactly the cycle after each cycle in which `start` is high, and is low otherwise. When `start` is low, `vec_out` keeps its value whatever the other inputs do.
- R3: The element size code `esz` is 0, 1, 2 or 3, meaning E = 1, 2, 4 or 8 bytes. Bit k of the packed field equals `pred[k*E]`. Predicate bits at other positions have no effect.
- R4: The packed field is `vl_bytes/E` bits wide and is placed starting at vector bit `index*width`.
- R5: With an effective index of 0, the field occupies the low bits and every other vector bit is zero.
- R6: With a nonzero effective index, only the addressed segment changes, and all other bits below the vector length equal `vec_in`.
- R7: For byte elements (`esz`=0), the low `vl_bytes` bits of `pred` are copied unchanged, `seg_idx` is ignored, and the rest of the vector is zero.
- R8: The effective index uses `seg_idx[0]` for halfwords, `seg_idx[1:0]` for words and `seg_idx[2:0]` for doublewords. Higher index bits are ignored.
- R9: A segment that straddles a 64-bit lane boundary is written correctly on both sides of the boundary.
- R10: Vector bits at index `vl_bytes*8` and above are always zero in a result. `vl_bytes` is a multiple of 16 between 16 and the maximum.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch one operation this cycle |
| vl_bytes | input | 8 | Current vector length in bytes |
| esz | input | 2 | Element size code (0=byte, 1=half, 2=word, 3=double) |
| seg_idx | input | 3 | Segment index |
| pred | input | 128 | Source predicate, one bit per vector byte |
| vec_in | input | 1024 | Current destination vector contents |
| vec_out | output | 1024 | Updated vector, held until the next operation |
| done | output | 1 | One-cycle result strobe |

## Verification
Two effects can land on the same result bits in one cycle:
- clearing the remainder when the index is zero, or keeping old segments when the index is nonzero;
- truncating everything at or above the vector length.

The bench provokes the overlap by feeding an all-ones `vec_in` while shortening the vector length to 80 and 48 bytes. With a nonzero index, the old ones must survive below VL and vanish above it.

A second overlap comes from back-to-back starts, where `done` for one operation coincides with the launch of the next. The scoreboard must then pair each result with the correct expected vector, in order.

// File: rtl/pvpack_pkg.sv
package pvpack_pkg;

    typedef enum logic [1:0] {
        ELEM_BYTE = 2'd0,
        ELEM_HALF = 2'd1,
        ELEM_WORD = 2'd2,
        ELEM_DBL  = 2'd3
    } elem_e;

    // Effective segment index: only as many index bits as the element size allows.
    function automatic logic [2:0] eff_index(input elem_e sz, input logic [2:0] idx);
        logic [2:0] r;
        case (sz)
            ELEM_BYTE: r = 3'd0;
            ELEM_HALF: r = {2'b00, idx[0]};
            ELEM_WORD: r = {1'b0, idx[1:0]};
            default:   r = idx;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pv_gather.sv
module pv_gather #(
    parameter int PRED_W = 128,
    parameter int LEN_W  = 8
) (
    input  logic [PRED_W-1:0] pred,
    input  pvpack_pkg::elem_e esz,
    input  logic [LEN_W-1:0]  vl_bytes,
    output logic [PRED_W-1:0] field,
    output logic [LEN_W-1:0]  width
);
    // One candidate field per element size; stride is 1 << e.
    logic [PRED_W-1:0] cand [4];

    for (genvar e = 0; e < 4; e++) begin : g_stride
        for (genvar k = 0; k < PRED_W; k++) begin : g_bit
            if ((k << e) < PRED_W) begin : g_in
                assign cand[e][k] = pred[k << e];
            end else begin : g_out
                assign cand[e][k] = 1'b0;
            end
        end
    end

    always_comb begin
        width = vl_bytes >> esz;
        for (int k = 0; k < PRED_W; k++) begin
            field[k] = (k < int'(width)) ? cand[esz][k] : 1'b0;
        end
    end

endmodule

// File: rtl/pv_merge.sv
module pv_merge #(
    parameter int VEC_W  = 1024,
    parameter int PRED_W = 128,
    parameter int LEN_W  = 8
) (
    input  logic [VEC_W-1:0]  old_vec,
    input  logic [PRED_W-1:0] field,
    input  logic [LEN_W-1:0]  width,
    input  logic [2:0]        idx,
    input  logic [LEN_W-1:0]  vl_bytes,
    output logic [VEC_W-1:0]  new_vec
);
    localparam int PAD = VEC_W - PRED_W;

    logic [VEC_W-1:0] lo_mask;
    logic [VEC_W-1:0] seg_mask;
    logic [VEC_W-1:0] seg_data;
    logic [VEC_W-1:0] len_mask;
    logic [VEC_W-1:0] kept;
    int               base;
    int               vl_bits;

    always_comb begin
        base    = int'(idx) * int'(width);
        vl_bits = int'(vl_bytes) * 8;

        for (int b = 0; b < VEC_W; b++) begin
            lo_mask[b]  = (b < int'(width));
            len_mask[b] = (b < vl_bits);
        end

        seg_mask = lo_mask << base;
        seg_data = {{PAD{1'b0}}, field} << base;

        // Index zero discards the old contents entirely.
        kept    = (idx == 3'd0) ? '0 : (old_vec & ~seg_mask);
        new_vec = (kept | seg_data) & len_mask;
    end

endmodule

// File: rtl/pred_vec_packer.sv
module pred_vec_packer #(
    parameter int MAX_VL_BYTES = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start,
    input  logic [7:0]                  vl_bytes,
    input  logic [1:0]                  esz,
    input  logic [2:0]                  seg_idx,
    input  logic [MAX_VL_BYTES-1:0]     pred,
    input  logic [MAX_VL_BYTES*8-1:0]   vec_in,
    output logic [MAX_VL_BYTES*8-1:0]   vec_out,
    output logic                        done
);
    import pvpack_pkg::*;

    localparam int PRED_W = MAX_VL_BYTES;
    localparam int VEC_W  = MAX_VL_BYTES * 8;
    localparam int LEN_W  = 8;

    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic             done;
    } state_t;

    state_t state_d, state_q;

    elem_e             size_code;
    logic [2:0]        idx_eff;
    logic [PRED_W-1:0] packed_field;
    logic [LEN_W-1:0]  field_width;
    logic [VEC_W-1:0]  merged;

    assign size_code = elem_e'(esz);
    assign idx_eff   = eff_index(size_code, seg_idx);

    pv_gather #(.PRED_W(PRED_W), .LEN_W(LEN_W)) u_gather (
        .pred     (pred),
        .esz      (size_code),
        .vl_bytes (vl_bytes),
        .field    (packed_field),
        .width    (field_width)
    );

    pv_merge #(.VEC_W(VEC_W), .PRED_W(PRED_W), .LEN_W(LEN_W)) u_merge (
        .old_vec  (vec_in),
        .field    (packed_field),
        .width    (field_width),
        .idx      (idx_eff),
        .vl_bytes (vl_bytes),
        .new_vec  (merged)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = start;
        if (start) begin
            state_d.vec = merged;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign vec_out = state_q.vec;
    assign done    = state_q.done;

    // Assertions
    assert_done_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> done);

    assert_done_only_after_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> $stable(vec_out));

    assert_above_vl_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((vec_out >> ({3'b000, $past(vl_bytes)} * 11'd8)) == '0));

    assert_idx0_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idx_eff == 3'd0) |=>
            ((vec_out >> PRED_W) == '0));

endmodule

// File: tb/pred_vec_packer_test.sv
module pred_vec_packer_test;

    localparam int MAXB = 128;
    localparam int VW   = MAXB * 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [7:0]      vl_bytes = 8'd128;
    logic [1:0]      esz = 2'd0;
    logic [2:0]      seg_idx = 3'd0;
    logic [MAXB-1:0] pred = '0;
    logic [VW-1:0]   vec_in = '0;
    logic [VW-1:0]   vec_out;
    logic            done;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [VW-1:0] vec;
        string         tag;
    } exp_t;

    exp_t sbq[$];
    logic [VW-1:0] last_exp = '0;

    always #10 clk = ~clk;

    pred_vec_packer #(.MAX_VL_BYTES(MAXB)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .vl_bytes(vl_bytes),
        .esz(esz), .seg_idx(seg_idx), .pred(pred), .vec_in(vec_in),
        .vec_out(vec_out), .done(done)
    );

    function automatic logic [VW-1:0] model(input logic [VW-1:0] old,
                                            input logic [MAXB-1:0] p,
                                            input int vl, input int sz, input int idx);
        logic [VW-1:0] r;
        int e, w, ei;
        e  = 1 << sz;
        w  = vl / e;
        ei = (sz == 0) ? 0 : (idx % (1 << sz));
        r  = (ei == 0) ? '0 : old;
        for (int b = 0; b < w; b++) r[ei * w + b] = p[b * e];
        for (int b = vl * 8; b < VW; b++) r[b] = 1'b0;
        return r;
    endfunction

    task automatic check(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Driver: called at a negedge; launches one operation and returns at the next negedge.
    task automatic issue(input string tag, input int vl, input int sz, input int idx,
                         input logic [MAXB-1:0] p, input logic [VW-1:0] old);
        exp_t it;
        vl_bytes = 8'(vl);
        esz      = 2'(sz);
        seg_idx  = 3'(idx);
        pred     = p;
        vec_in   = old;
        start    = 1'b1;
        it.vec   = model(old, p, vl, sz, idx);
        it.tag   = tag;
        last_exp = it.vec;
        sbq.push_back(it);
        @(negedge clk);
        check("R2 done after start", {1023'd0, done}, {1023'd0, 1'b1});
    endtask

    task automatic op(input string tag, input int vl, input int sz, input int idx,
                      input logic [MAXB-1:0] p, input logic [VW-1:0] old);
        issue(tag, vl, sz, idx, p, old);
        start = 1'b0;
        @(negedge clk);
        check("R2 done single pulse", {1023'd0, done}, {1023'd0, 1'b0});
    endtask

    // Monitor: pops expected items whenever the design reports a result.
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (sbq.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R2 unexpected done actual=1 expected=0");
            end else begin
                exp_t it;
                it = sbq.pop_front();
                check(it.tag, vec_out, it.vec);
            end
        end
    end

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [MAXB-1:0] pa, podd;
        logic [VW-1:0]   ones;
        pa   = {4{32'hA5C3_96E1}};
        podd = {32{4'b1010}};
        ones = '1;

        repeat (3) @(negedge clk);
        check("R1 reset vec", vec_out, '0);
        check("R1 reset done", {1023'd0, done}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", vec_out, '0);

        op("R7 byte copy", 128, 0, 0, pa, ones);
        op("R7 byte index ignored", 128, 0, 5, ~pa, ones);
        op("R5 R3 half idx0", 128, 1, 0, pa, ones);
        op("R6 R4 half idx1", 128, 1, 1, pa, ones);
        op("R6 R4 word idx2", 128, 2, 2, pa, ones);
        op("R4 dword idx7", 128, 3, 7, pa, ones);
        op("R3 odd pred bits ignored", 128, 1, 1, podd, ones);
        op("R8 high index bit ignored", 128, 1, 3, pa, '0);
        op("R8 word idx 6 -> 2", 128, 2, 6, pa, ones);
        op("R9 R10 dword crossing lane", 80, 3, 6, ~pa, ones);
        op("R9 R10 word crossing lane", 80, 2, 3, pa, ones);
        op("R10 R6 short VL half", 48, 1, 1, pa, ones);
        op("R5 R10 short VL idx0", 16, 3, 0, pa, ones);

        // Back-to-back starts.
        issue("R2 b2b first", 128, 2, 1, pa, ones);
        issue("R2 b2b second", 64, 3, 3, ~pa, {VW/8{8'h5A}});
        start = 1'b0;
        @(negedge clk);
        check("R2 done drops after b2b", {1023'd0, done}, '0);

        // Hold: change every input without start.
        vl_bytes = 8'd32; esz = 2'd0; seg_idx = 3'd0; pred = '1; vec_in = '0;
        repeat (2) @(negedge clk);
        check("R2 hold without start", vec_out, last_exp);
        check("R2 no done without start", {1023'd0, done}, '0);
        check("R2 scoreboard drained", VW'(sbq.size()), '0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule